// File: doc/BRIEF.md
# Multistage Barrel Shifter

This block shifts a data word by any distance from zero up to one less than the word width, in one combinational pass. A 2-bit kind code selects the shift: pass through, logical left, logical right, or arithmetic right. The amount is an unsigned binary number. Each amount bit drives one stage of a multiplexer chain, and that stage either applies a fixed power-of-two shift or passes its input unchanged. The stages run from the largest distance to the smallest (16, 8, 4, 2, 1 at the default width).

An execution unit uses the block next to its adder and logic unit and feeds its result into the final result select. The block has no clock and holds no state. The output settles from the inputs alone, and the caller places any registers around it. Rotates are not supported. There is no valid/ready handshake, because the block neither buffers data nor applies back-pressure. One word goes in and one result comes out in the same cycle, so the caller's own pipeline decides when the result is used.

Top module: `shf_barrel`

## Requirements
- R1: With kind code 2'b00 (pass), the output equals the input for every amount.
- R2: With amount 0, the output equals the input for every kind code.
- R3: With kind code 2'b01 (logical left), the output is the input shifted toward bit 31 by the amount, and the vacated low bits are 0.
- R4: With kind code 2'b10 (logical right), the output is the input shifted toward bit 0 by the amount, and the vacated high bits are 0.
- R5: With kind code 2'b11 (arithmetic right), the output is the input shifted toward bit 0 by the amount, and every vacated high bit equals input bit 31.
- R6: The full amount range 0 to 31 is covered. At 31, a left shift moves input bit 0 to bit 31, and a right shift moves input bit 31 to bit 0.
- R7: Any amount gives the same result as applying its set bits as separate power-of-two shifts, so sums of stage distances such as 5, 21 and 30 are correct.
- R8: The output is purely combinational. It reflects new inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | 32 | Word to be shifted |
| kind | input  | 2  | Shift kind: 00 pass, 01 logical left, 10 logical right, 11 arithmetic right |
| amt  | input  | 5  | Unsigned shift distance, 0 to 31 |
| dout | output | 32 | Shifted word |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Arithmetic right shifts of negative words at every distance:** a fill that drops to zero in any one stage leaves a hole of zeros among the sign copies.
- **Every amount from 0 to 31 under each kind:** a stage wired to the wrong amount bit, or to the wrong distance, produces mismatches at exactly the amounts that use that bit.
- **The extreme distance of 31:** a right shift that is off by one loses the last surviving bit.
- **Pass kind and zero amount:** a mux that shifts when it should hold corrupts these words.
- **Inputs changed without a clock edge:** a stray register would show up as stale output.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHK_PASS  = 2'b00,
    SHK_LEFT  = 2'b01,
    SHK_RIGHT = 2'b10,
    SHK_ARITH = 2'b11
  } shf_kind_e;
endpackage

// File: rtl/shf_fill.sv
// Chooses the bit that fills vacated positions: the original sign for an
// arithmetic right shift, zero otherwise.
module shf_fill
  import shf_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       sign,
  output logic       fill
);
  always_comb begin
    fill = 1'b0;
    if (kind == SHK_ARITH) fill = sign;
  end
endmodule

// File: rtl/shf_stage.sv
// One conditional fixed-distance shift. The kind code selects the direction;
// when en is low the word passes through untouched.
module shf_stage
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] d,
  input  logic [1:0]       kind,
  input  logic             en,
  input  logic             fill,
  output logic [WIDTH-1:0] q
);
  localparam int KEEP = WIDTH - DIST;

  logic [DIST-1:0] fill_vec;
  assign fill_vec = {DIST{fill}};

  always_comb begin
    q = d;
    if (en) begin
      unique case (kind)
        SHK_PASS:  q = d;
        SHK_LEFT:  q = {d[KEEP-1:0], {DIST{1'b0}}};
        SHK_RIGHT: q = {{DIST{1'b0}}, d[WIDTH-1:DIST]};
        SHK_ARITH: q = {fill_vec, d[WIDTH-1:DIST]};
        default:   q = d;
      endcase
    end
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dout
);
  // chain[AMT_W] is the input; chain[0] is the result. The stage for amount
  // bit i sits between chain[i+1] and chain[i], so the largest distance is first.
  logic [WIDTH-1:0] chain [AMT_W+1];
  logic             fill;

  shf_fill u_fill (
    .kind (kind),
    .sign (din[WIDTH-1]),
    .fill (fill)
  );

  assign chain[AMT_W] = din;

  for (genvar i = AMT_W - 1; i >= 0; i--) begin : g_stage
    shf_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << i)
    ) u_stage (
      .d    (chain[i+1]),
      .kind (kind),
      .en   (amt[i]),
      .fill (fill),
      .q    (chain[i])
    );
  end

  assign dout = chain[0];
endmodule

// File: rtl/shf_barrel_chk.sv
module shf_barrel_chk #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] din,
  input logic [1:0]       kind,
  input logic [AMT_W-1:0] amt,
  input logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] low_mask, high_mask, sign_fill;

  always_comb begin
    low_mask  = ~({WIDTH{1'b1}} << amt);
    high_mask = ~({WIDTH{1'b1}} >> amt);
    sign_fill = din[WIDTH-1] ? high_mask : '0;

    AST_PASS_KIND: assert (kind != 2'b00 || dout == din)
      else $error("pass kind changed data");                          // R1
    AST_ZERO_AMT: assert (amt != '0 || dout == din)
      else $error("zero amount changed data");                        // R2
    AST_LEFT_FILL: assert (kind != 2'b01 || (dout & low_mask) == '0)
      else $error("left shift low fill not zero");                    // R3
    AST_RIGHT_FILL: assert (kind != 2'b10 || (dout & high_mask) == '0)
      else $error("logical right high fill not zero");                // R4
    AST_ARITH_FILL: assert (kind != 2'b11 || (dout & high_mask) == sign_fill)
      else $error("arithmetic fill not sign copies");                 // R5
    AST_ARITH_SIGN: assert (kind != 2'b11 || dout[WIDTH-1] == din[WIDTH-1])
      else $error("arithmetic shift lost the sign");                  // R5
  end
endmodule

bind shf_barrel shf_barrel_chk #(.WIDTH(WIDTH)) u_chk (
  .din  (din),
  .kind (kind),
  .amt  (amt),
  .dout (dout)
);

// File: tb/tb_shf_barrel.sv
`timescale 1ns/1ps
module tb_shf_barrel;
  logic        clk = 1'b0;
  logic [31:0] din;
  logic [1:0]  kind;
  logic [4:0]  amt;
  logic [31:0] dout;
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shf_barrel dut (.din(din), .kind(kind), .amt(amt), .dout(dout));

  function automatic logic [31:0] model(logic [31:0] d, logic [1:0] k, logic [4:0] a);
    case (k)
      2'b01:   return d << a;
      2'b10:   return d >> a;
      2'b11:   return 32'($signed(d) >>> a);
      default: return d;
    endcase
  endfunction

  task automatic apply(input logic [31:0] d, input logic [1:0] k, input logic [4:0] a,
                       input string req);
    logic [31:0] exp;
    @(negedge clk);
    din = d; kind = k; amt = a;
    #1;
    exp = model(d, k, a);
    n_vec++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s: din=%h kind=%b amt=%0d got %h expected %h", req, d, k, a, dout, exp);
    end
  endtask

  task automatic t_idle;       // settle state with zero inputs (R2)
    apply(32'h0, 2'b00, 5'd0, "R2");
  endtask

  task automatic t_pass;       // R1
    for (int a = 0; a < 32; a++) apply(32'hA5C3_0F96 ^ a, 2'b00, 5'(a), "R1");
  endtask

  task automatic t_zero_amt;   // R2
    for (int k = 0; k < 4; k++) apply(32'h8123_4567, 2'(k), 5'd0, "R2");
  endtask

  task automatic t_left;       // R3
    for (int a = 0; a < 32; a++) apply(32'hDEAD_BEEF, 2'b01, 5'(a), "R3");
    for (int a = 0; a < 32; a++) apply(32'h0000_0001, 2'b01, 5'(a), "R3");
  endtask

  task automatic t_lright;     // R4
    for (int a = 0; a < 32; a++) apply(32'hF0F0_1234, 2'b10, 5'(a), "R4");
    for (int a = 0; a < 32; a++) apply(32'h8000_0000, 2'b10, 5'(a), "R4");
  endtask

  task automatic t_aright;     // R5
    for (int a = 0; a < 32; a++) apply(32'h8000_0001, 2'b11, 5'(a), "R5");
    for (int a = 0; a < 32; a++) apply(32'h7FFF_FFFE, 2'b11, 5'(a), "R5");
    for (int a = 0; a < 32; a++) apply(32'hC3A5_5A3C, 2'b11, 5'(a), "R5");
  endtask

  task automatic t_extreme;    // R6
    apply(32'h0000_0001, 2'b01, 5'd31, "R6");
    apply(32'h8000_0000, 2'b10, 5'd31, "R6");
    apply(32'h8000_0000, 2'b11, 5'd31, "R6");
    apply(32'h4000_0000, 2'b11, 5'd31, "R6");
  endtask

  task automatic t_compose;    // R7: amounts mixing several stages
    logic [31:0] pat;
    pat = 32'h1357_9BDF;
    for (int i = 0; i < 200; i++) begin
      pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
      apply(pat, 2'(i), 5'(i * 7 + 3), "R7");
    end
  endtask

  task automatic t_comb;       // R8: output follows input between edges
    @(negedge clk);
    din = 32'h0000_00F0; kind = 2'b10; amt = 5'd4;
    #0.5;
    n_vec++;
    if (dout !== 32'h0000_000F) begin
      n_fail++;
      $display("FAIL R8: got %h expected %h", dout, 32'h0000_000F);
    end
    amt = 5'd8;
    #0.5;
    n_vec++;
    if (dout !== 32'h0000_0000) begin
      n_fail++;
      $display("FAIL R8: got %h expected %h", dout, 32'h0000_0000);
    end
  endtask

  initial begin
    din = '0; kind = '0; amt = '0;
    t_idle();
    t_pass();
    t_zero_amt();
    t_left();
    t_lright();
    t_aright();
    t_extreme();
    t_compose();
    t_comb();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule